// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when the DRAM is refreshed and generates the strobe waveforms for each refresh. A free-running interval timer adds one unit to a pending-refresh credit counter every time a refresh period elapses. While credits are pending, the block raises a request towards the access controller. Once the controller grants, and no page cycle is in progress, the block takes over the row strobe, both byte column strobes and the write strobe. It then runs one refresh cycle in which the column strobes fall before the row strobe, so that the device's own row counter picks the row. Each completed cycle retires one credit.

A low-power request makes the block surround self-refresh with guard refreshes. In burst mode these are a full burst of cycles; in distributed mode a single cycle is used. The block then holds both strobes low long enough for the device to refresh itself. A wake input is honoured only after that minimum hold. The block then applies the long self-refresh precharge and runs the same number of guard refreshes again before it hands the bus back with a fresh interval and no pending credits.

All durations are counted in clock cycles and set by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: Out of reset, `credits` is 0, `ref_req` is low, `ras_n` is 1 and `cas_n` is 2'b11. With no grant, `credits` rises by exactly one every `INTERVAL_CYC` clock cycles, and `ref_req` is high whenever the block is idle with `credits` non-zero.
- R2: `credits` never exceeds `CRED_MAX`, and further interval expiries leave it at that value. `ref_sat` is high exactly when `credits` equals `CRED_MAX`, a request is pending and `ref_gnt` is low.
- R3: `ref_urgent` is high when a request is pending and at least two credits have accumulated, meaning a full interval has passed since the request was raised.
- R4: A refresh cycle starts on the clock edge at which `ref_gnt` is high and `page_busy` is low while `ref_req` is high. From that edge, `cas_n` is 2'b00 with `ras_n` high for `CSR_CYC` cycles. Then `ras_n` is low for `RAS_CYC` cycles, with `cas_n` kept at 2'b00 for the first `CHR_CYC` of them and at 2'b11 afterwards. Then both strobes are high for `RP_CYC` cycles. `bus_own` is high for the whole cycle, and `credits` drops by one at the edge where `bus_own` falls.
- R5: `we_n` is 1 in every cycle, including throughout refresh and self-refresh, so the write strobe stays high around every fall of `ras_n`.
- R6: While `page_busy` is high, a grant does not start a refresh: `bus_own` stays low and `ras_n` stays high.
- R7: A pulse on `lp_req` produces guard refresh cycles (`NSURR` = `BURST_N` in burst mode, else 1). These are followed by a self-refresh entry in which `cas_n` falls before `ras_n` and both then stay low.
- R8: `sr_active` rises only after `ras_n` has been low for `SR_MIN_CYC` consecutive cycles of self-refresh. A `wake` pulse before that point is ignored.
- R9: After `wake` is accepted, `ras_n` and `cas_n` are both high for `RPS_CYC` cycles. `NSURR` further refresh cycles follow, after which `bus_own` falls with `credits` equal to 0 and `sr_active` low.
- R10: The interval timer is held cleared during the self-refresh flow, so the first new credit appears exactly `INTERVAL_CYC` cycles after `bus_own` falls at the end of the flow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_gnt | input | 1 | Grant from the access controller |
| page_busy | input | 1 | A page cycle is in progress and must not be cut |
| lp_req | input | 1 | Request to put the memory into self-refresh |
| wake | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh request to the access controller |
| ref_urgent | output | 1 | Refresh takes priority over new accesses |
| ref_sat | output | 1 | Credit counter full while the request is not granted |
| bus_own | output | 1 | Block is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Byte column strobes, active low, [1] upper, [0] lower |
| we_n | output | 1 | Write strobe, active low |
| sr_active | output | 1 | Memory is in self-refresh and may be woken |
| credits | output | $clog2(CRED_MAX+1) | Pending refresh credits |

## Verification
Credits update on the clock edge after the timer's terminal count, so the bench waits whole multiples of `INTERVAL_CYC` edges from reset release before it samples `credits`, `ref_urgent` and `ref_sat` at the following falling edge. The strobes are decoded from registered state, so the first refresh-cycle value appears one edge after the grant. The bench therefore compares the strobes sample by sample against an expected eight-cycle pattern that ends with `bus_own` low and the credit retired. For self-refresh, the bench counts `ras_n` falls and consecutive low and high samples at falling edges, rather than fixed cycle numbers. It then counts exactly `INTERVAL_CYC` edges from the release of the bus to the first new credit.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CSETUP,
    SQ_RLOW,
    SQ_PRECH,
    SQ_SR_CSETUP,
    SQ_SR_HOLD,
    SQ_SR_EXIT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_REGULAR,
    PH_GUARD_IN,
    PH_GUARD_OUT
  } seq_phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refsch_timer.sv
module refsch_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == TW'(INTERVAL_CYC - 1));
  assign tick = wrap && !clr;

  always_comb begin
    if (clr || wrap) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

endmodule

// File: rtl/refsch_credit.sv
module refsch_credit #(
  parameter int CRED_MAX = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic                            dec,
  input  logic                            clr,
  output logic [$clog2(CRED_MAX+1)-1:0]   cred
);
  localparam int CRW = $clog2(CRED_MAX + 1);

  logic [CRW-1:0] cred_q, cred_d;
  logic           full, up, dn;

  assign full = (cred_q == CRW'(CRED_MAX));
  assign up   = tick;
  assign dn   = dec && (cred_q != '0);
  assign cred = cred_q;

  always_comb begin
    cred_d = cred_q;
    if (clr)              cred_d = '0;
    else if (up && !dn)   cred_d = full ? cred_q : cred_q + 1'b1;
    else if (dn && !up)   cred_d = cred_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cred_q <= '0;
    else        cred_q <= cred_d;
  end

  AST_CRED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= CRW'(CRED_MAX)); // R2

  AST_CRED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_q == $past(cred_q)) || (cred_q == $past(cred_q) + 1'b1) ||
    (cred_q + 1'b1 == $past(cred_q)) || (cred_q == '0)); // R1

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
  import refsch_pkg::*;
#(
  parameter int CSR_CYC    = 1,
  parameter int CHR_CYC    = 2,
  parameter int RAS_CYC    = 5,
  parameter int RP_CYC     = 4,
  parameter int RPS_CYC    = 11,
  parameter int SR_MIN_CYC = 10000,
  parameter int NSURR      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lp_go,
  input  logic       wake,
  output logic       idle,
  output logic       done,
  output logic       sr_flow,
  output logic       sr_act,
  output logic       ras_n,
  output logic [1:0] cas_n
);
  localparam int MAXC = imax(imax(imax(CSR_CYC, RAS_CYC), imax(RP_CYC, RPS_CYC)), SR_MIN_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(NSURR + 1);

  seq_state_e     st_q, st_d;
  seq_phase_e     ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [RW-1:0]  rem_q, rem_d;
  logic           cas_low;

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    rem_d = rem_q;
    cnt_d = cnt_q + 1'b1;
    done  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (start) begin
          st_d  = SQ_CSETUP;
          ph_d  = lp_go ? PH_GUARD_IN : PH_REGULAR;
          rem_d = RW'(NSURR);
        end
      end
      SQ_CSETUP: if (cnt_q == CW'(CSR_CYC - 1)) begin
        st_d  = SQ_RLOW;
        cnt_d = '0;
      end
      SQ_RLOW: if (cnt_q == CW'(RAS_CYC - 1)) begin
        st_d  = SQ_PRECH;
        cnt_d = '0;
      end
      SQ_PRECH: if (cnt_q == CW'(RP_CYC - 1)) begin
        cnt_d = '0;
        done  = 1'b1;
        if (ph_q == PH_REGULAR) begin
          st_d = SQ_IDLE;
        end else if (rem_q > RW'(1)) begin
          rem_d = rem_q - 1'b1;
          st_d  = SQ_CSETUP;
        end else if (ph_q == PH_GUARD_IN) begin
          st_d = SQ_SR_CSETUP;
        end else begin
          st_d = SQ_IDLE;
          ph_d = PH_REGULAR;
        end
      end
      SQ_SR_CSETUP: if (cnt_q == CW'(CSR_CYC - 1)) begin
        st_d  = SQ_SR_HOLD;
        cnt_d = '0;
      end
      SQ_SR_HOLD: begin
        if (cnt_q == CW'(SR_MIN_CYC)) cnt_d = cnt_q;
        if (sr_act && wake) begin
          st_d  = SQ_SR_EXIT;
          cnt_d = '0;
        end
      end
      SQ_SR_EXIT: if (cnt_q == CW'(RPS_CYC - 1)) begin
        st_d  = SQ_CSETUP;
        cnt_d = '0;
        ph_d  = PH_GUARD_OUT;
        rem_d = RW'(NSURR);
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ph_q  <= PH_REGULAR;
      cnt_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
    end
  end

  assign idle    = (st_q == SQ_IDLE);
  assign sr_flow = (ph_q != PH_REGULAR);
  assign sr_act  = (st_q == SQ_SR_HOLD) && (cnt_q == CW'(SR_MIN_CYC));
  assign cas_low = (st_q == SQ_CSETUP) || (st_q == SQ_SR_CSETUP) || (st_q == SQ_SR_HOLD) ||
                   ((st_q == SQ_RLOW) && (cnt_q < CW'(CHR_CYC)));
  assign ras_n   = !((st_q == SQ_RLOW) || (st_q == SQ_SR_HOLD));
  assign cas_n   = {2{!cas_low}};

  // Independent run-length of the row strobe, used only by the checks below
  logic [CW-1:0] lowrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lowrun_q <= '0;
    else if (ras_n)                         lowrun_q <= '0;
    else if (lowrun_q != CW'(SR_MIN_CYC))   lowrun_q <= lowrun_q + 1'b1;
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 2'b00)); // R4

  AST_SR_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    sr_act |-> (lowrun_q == CW'(SR_MIN_CYC))); // R8

  AST_SR_EXIT_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && $past(sr_act) |-> (cas_n == 2'b11)); // R9

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL_CYC = 1560,
  parameter int CRED_MAX     = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 4,
  parameter int RPS_CYC      = 11,
  parameter int SR_MIN_CYC   = 10000,
  parameter bit BURST_MODE   = 1'b0,
  parameter int BURST_N      = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_gnt,
  input  logic                          page_busy,
  input  logic                          lp_req,
  input  logic                          wake,
  output logic                          ref_req,
  output logic                          ref_urgent,
  output logic                          ref_sat,
  output logic                          bus_own,
  output logic                          ras_n,
  output logic [1:0]                    cas_n,
  output logic                          we_n,
  output logic                          sr_active,
  output logic [$clog2(CRED_MAX+1)-1:0] credits
);
  localparam int CRW   = $clog2(CRED_MAX + 1);
  localparam int NSURR = BURST_MODE ? BURST_N : 1;

  logic           tick, done, idle, sr_flow, start;
  logic           lp_pend_q, lp_pend_d;
  logic [CRW-1:0] cred;

  refsch_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(sr_flow), .tick(tick)
  );

  refsch_credit #(.CRED_MAX(CRED_MAX)) u_credit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(done && !sr_flow),
    .clr(sr_flow), .cred(cred)
  );

  refsch_seq #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .RPS_CYC(RPS_CYC), .SR_MIN_CYC(SR_MIN_CYC), .NSURR(NSURR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lp_go(lp_pend_q), .wake(wake),
    .idle(idle), .done(done), .sr_flow(sr_flow), .sr_act(sr_active),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  assign ref_req    = idle && ((cred != '0) || lp_pend_q);
  assign start      = ref_req && ref_gnt && !page_busy;
  assign ref_urgent = ref_req && (cred >= CRW'(2));
  assign ref_sat    = ref_req && !ref_gnt && (cred == CRW'(CRED_MAX));
  assign bus_own    = !idle;
  assign we_n       = 1'b1;
  assign credits    = cred;

  always_comb begin
    lp_pend_d = lp_pend_q;
    if (start && lp_pend_q)     lp_pend_d = 1'b0;
    else if (lp_req && !sr_flow) lp_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_pend_q <= 1'b0;
    else        lp_pend_q <= lp_pend_d;
  end

  AST_URGENT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req); // R3

  AST_PAGE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (page_busy && !bus_own) |=> !bus_own); // R6

  AST_SAT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sat |-> (credits == CRW'(CRED_MAX)) && !ref_gnt); // R2

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_P    = 10;
  localparam int INTV     = 20;
  localparam int CMAX     = 8;
  localparam int RAS_C    = 4;
  localparam int RP_C     = 2;
  localparam int RPS_C    = 5;
  localparam int SRMIN    = 30;
  localparam int NBURST   = 3;
  localparam int NV       = 5;

  // Vector table: intervals waited without a grant and the expected results
  localparam int WAIT_N[NV]    = '{1, 2, 5, 8, 10};
  localparam int EXP_CRED[NV]  = '{1, 2, 5, 8, 8};
  localparam int EXP_URG[NV]   = '{0, 1, 1, 1, 1};
  localparam int EXP_SAT[NV]   = '{0, 0, 0, 1, 1};
  localparam int EXP_AFTER[NV] = '{0, 1, 4, 7, 7};

  // Expected strobe samples k=1..8 after the grant edge (bit k-1)
  localparam logic [7:0] PAT_RAS = 8'b1110_0001;
  localparam logic [7:0] PAT_CAS = 8'b1111_1000;
  localparam logic [7:0] PAT_OWN = 8'b0111_1111;

  logic       clk, rst_n, ref_gnt, page_busy, lp_req, wake;
  logic       ref_req, ref_urgent, ref_sat, bus_own, ras_n, we_n, sr_active;
  logic [1:0] cas_n;
  logic [3:0] credits;

  int  n_chk, n_fail;
  bit  finished;

  dram_refresh_sched #(
    .INTERVAL_CYC(INTV), .CRED_MAX(CMAX), .CSR_CYC(1), .CHR_CYC(2),
    .RAS_CYC(RAS_C), .RP_CYC(RP_C), .RPS_CYC(RPS_C), .SR_MIN_CYC(SRMIN),
    .BURST_MODE(1'b1), .BURST_N(NBURST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .page_busy(page_busy),
    .lp_req(lp_req), .wake(wake), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_sat(ref_sat), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .sr_active(sr_active), .credits(credits)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_gnt = 1'b0; page_busy = 1'b0; lp_req = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset credits", int'(credits), 0);
    chk("R1 reset ref_req", int'(ref_req), 0);
    chk("R1 reset ras_n", int'(ras_n), 1);
    chk("R1 reset cas_n", int'(cas_n), 3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;

    // Table walk: credit build-up, urgency, saturation, then one CBR cycle
    for (int v = 0; v < NV; v++) begin
      do_reset();
      repeat (WAIT_N[v] * INTV) @(posedge clk);
      @(negedge clk);
      chk("R1 credits after intervals", int'(credits), EXP_CRED[v]);
      chk("R1 ref_req pending", int'(ref_req), 1);
      chk("R2 credit limit", int'(credits), EXP_CRED[v]);
      chk("R2 ref_sat", int'(ref_sat), EXP_SAT[v]);
      chk("R3 ref_urgent", int'(ref_urgent), EXP_URG[v]);
      ref_gnt = 1'b1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (k == 1) ref_gnt = 1'b0;
        chk("R4 ras_n pattern", int'(ras_n), int'(PAT_RAS[k-1]));
        chk("R4 cas_n pattern", int'(cas_n), PAT_CAS[k-1] ? 3 : 0);
        chk("R4 bus_own pattern", int'(bus_own), int'(PAT_OWN[k-1]));
        chk("R5 we_n high", int'(we_n), 1);
      end
      chk("R4 credit retired", int'(credits), EXP_AFTER[v]);
    end

    // R6: a granted refresh waits for the page cycle to finish
    do_reset();
    repeat (INTV) @(posedge clk);
    @(negedge clk);
    page_busy = 1'b1; ref_gnt = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 no start in page cycle", int'(bus_own), 0);
      chk("R6 ras_n held high", int'(ras_n), 1);
    end
    page_busy = 1'b0;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk("R6 start after page cycle", int'(bus_own), 1);
    repeat (10) @(negedge clk);

    // R7-R10: self-refresh with guard bursts
    do_reset();
    @(negedge clk);
    lp_req = 1'b1; ref_gnt = 1'b1;
    @(negedge clk);
    lp_req = 1'b0;
    begin
      int  falls, lowrun, hi;
      bit  prev_ras, seen, woke, stop;
      falls = 0; lowrun = 0; prev_ras = 1'b1; seen = 1'b0; woke = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin
        @(negedge clk);
        if (prev_ras && !ras_n) falls++;
        if (sr_active) seen = 1'b1;
        else if (!ras_n) lowrun++;
        else lowrun = 0;
        if (!ras_n && lowrun == 10 && !woke) begin
          wake = 1'b1; woke = 1'b1;
        end else begin
          wake = 1'b0;
        end
        prev_ras = ras_n;
      end
      ref_gnt = 1'b0;
      chk("R7 self-refresh reached", int'(seen), 1);
      chk("R7 guard cycles plus entry", falls, NBURST + 1);
      chk("R7 cas_n low in self-refresh", int'(cas_n), 0);
      chk("R8 early wake ignored, hold length", lowrun, SRMIN);
      chk("R5 we_n high in self-refresh", int'(we_n), 1);

      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      hi = 0; stop = 1'b0;
      for (int i = 0; i < 50 && !stop; i++) begin
        if (ras_n && cas_n == 2'b11) begin
          hi++;
          @(negedge clk);
        end else begin
          stop = 1'b1;
        end
      end
      chk("R9 long precharge", hi, RPS_C);
      falls = 0; prev_ras = ras_n;
      for (int i = 0; i < 200 && bus_own; i++) begin
        @(negedge clk);
        if (prev_ras && !ras_n) falls++;
        prev_ras = ras_n;
      end
      chk("R9 guard cycles after exit", falls, NBURST);
      chk("R9 bus released", int'(bus_own), 0);
      chk("R9 credits cleared", int'(credits), 0);
      chk("R9 sr_active low", int'(sr_active), 0);
      repeat (INTV - 1) @(negedge clk);
      chk("R10 no credit before interval", int'(credits), 0);
      @(negedge clk);
      chk("R10 first credit after interval", int'(credits), 1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule